// File: doc/BRIEF.md
# Serial Tuner Control Word Receiver

This block takes control words for a tuner synthesizer from a slow three-line serial port made up of a frame select, a shift clock and a data line. It loads three banks of parallel latches: a 4-bit band select, a 15-bit divider ratio and a 7-bit feature/test word. All three lines are synchronized into a fast system clock. Edges of the shift clock are found by comparing successive synchronized samples. The shift clock has to be much slower than the system clock. With the 50 MHz system clock and the default two-stage synchronizers, a shift clock of 100 kHz or less leaves a wide margin.

No length field is sent. The receiver counts shift-clock pulses while the frame select is high, and it loads each bank when that count reaches a fixed value. A frame ended early therefore updates only the banks whose pulse count it reached. Bits beyond the longest frame are dropped. A short divider frame is detected when the frame select falls right after the eighteenth pulse. In that case the divider is loaded from the fourteen bits received and its top bit is forced to zero. Each bank load also drives a one-cycle strobe. The divider bank powers up at 256 so that the downstream divider starts at a safe ratio. The feature bank powers up cleared, which selects the lower reference ratio (512). The higher ratio can only be chosen through a full-length frame.

Top module: `tuner_ctl_rx`

## Requirements
- R1: While reset is held, and right after it, band_q is 0, div_q is 256, feat_q is 0 (feat_q[5]=0 means reference ratio 512) and all strobes are low.
- R2: A frame starts when ser_en rises. Data is taken on each rising ser_clk edge, first bit first. On the falling edge of pulse 4, band_q is loaded from pulses 1..4, with pulse 1 landing in band_q[3].
- R3: In any frame that reaches pulse 19, div_q is loaded on the falling edge of pulse 19 from pulses 5..19, with pulse 5 landing in div_q[14].
- R4: When ser_en falls after exactly 18 pulses, div_q is loaded from pulses 5..18 into div_q[13:0] and div_q[14] is cleared. No other frame length clears div_q[14].
- R5: In a frame that reaches pulse 34, feat_q is loaded on the falling edge of pulse 34 from pulses 20..26, with pulse 20 landing in feat_q[6]. Pulses 27..34 are don't-care. feat_q[5]=1 selects reference ratio 1024.
- R6: A frame that stops before pulse 4 changes no bank. A frame that stops between pulses 4 and 17, or between 19 and 33, keeps only the banks already completed.
- R7: Pulses after pulse 34 are ignored. A 40-pulse frame leaves the same bank contents as its first 34 pulses.
- R8: While ser_en is low, ser_clk and ser_dat activity changes no bank and raises no strobe.
- R9: Each bank load raises its strobe (band_stb, div_stb, feat_stb) for exactly one system cycle, once per frame, and the new bank value appears on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| ser_en | input | 1 | Serial frame select, high during a frame |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, sampled on rising ser_clk |
| band_q | output | 4 | Band select latch |
| div_q | output | 15 | Divider ratio latch |
| feat_q | output | 7 | Feature/test latch |
| band_stb | output | 1 | One-cycle pulse on band load |
| div_stb | output | 1 | One-cycle pulse on divider load |
| feat_stb | output | 1 | One-cycle pulse on feature load |

## Verification
The bench sends frames of 3, 4, 9, 18, 19, 30, 34 and 40 pulses and compares every bank and strobe count against a model built from the pulse-count rules. An 18-pulse frame that sends a 1 in every position exposes a design that keeps the divider top bit, or that shifts the short word by one place. A 30-pulse frame exposes a receiver that loads the feature bank when the frame select falls instead of at pulse 34. A 40-pulse frame exposes one that keeps shifting past the limit and so takes the wrong feature bits. Clock toggling with the frame select low catches a counter that is not held idle.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
   typedef struct packed {
      logic band;
      logic div;
      logic feat;
   } tcr_stb_t;

   function automatic int unsigned tcr_cnt_w(input int unsigned max_pulses);
      return $clog2(max_pulses + 2);
   endfunction
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("tcr_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tcr_frame.sv
module tcr_frame
   import tcr_pkg::*;
#(
   parameter int unsigned BAND_W    = 4,
   parameter int unsigned DIV_W     = 15,
   parameter int unsigned FEAT_W    = 7,
   parameter int unsigned FRAME_MAX = 34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sck,
   input  logic              sdi,
   output tcr_stb_t          stb,
   output logic [BAND_W-1:0] band_pl,
   output logic [DIV_W-1:0]  div_pl,
   output logic [FEAT_W-1:0] feat_pl
);
   localparam int unsigned DIV_END  = BAND_W + DIV_W;
   localparam int unsigned FEAT_END = DIV_END + FEAT_W;
   localparam int unsigned CW       = tcr_cnt_w(FRAME_MAX);
   localparam int unsigned FEAT_HI  = FRAME_MAX - DIV_END - 1;
   localparam int unsigned FEAT_LO  = FRAME_MAX - FEAT_END;

   generate
      if (FEAT_END > FRAME_MAX) begin : g_bad_len
         $error("fields exceed frame length");
      end
   endgenerate

   logic          en_d, sck_d;
   logic [CW-1:0] cnt;
   logic [FRAME_MAX-1:0] sr;
   logic          sck_rise, sck_fall, en_fall;
   logic          hit_band, hit_div_long, hit_div_short, hit_feat;

   assign sck_rise = sck & ~sck_d;
   assign sck_fall = ~sck & sck_d;
   assign en_fall  = en_d & ~en;

   assign hit_band      = en & sck_fall & (cnt == CW'(BAND_W));
   assign hit_div_long  = en & sck_fall & (cnt == CW'(DIV_END));
   assign hit_div_short = en_fall & (cnt == CW'(DIV_END - 1));
   assign hit_feat      = en & sck_fall & (cnt == CW'(FRAME_MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d  <= 1'b0;
         sck_d <= 1'b0;
         cnt   <= '0;
         sr    <= '0;
      end else begin
         en_d  <= en;
         sck_d <= sck;
         if (!en) begin
            cnt <= '0;
         end else if (sck_rise && (cnt <= CW'(FRAME_MAX))) begin
            cnt <= cnt + 1'b1;
            if (cnt < CW'(FRAME_MAX)) sr <= {sr[FRAME_MAX-2:0], sdi};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb     <= '0;
         band_pl <= '0;
         div_pl  <= '0;
         feat_pl <= '0;
      end else begin
         stb.band <= hit_band;
         stb.div  <= hit_div_long | hit_div_short;
         stb.feat <= hit_feat;
         if (hit_band) band_pl <= sr[BAND_W-1:0];
         if (hit_div_long)       div_pl <= sr[DIV_W-1:0];
         else if (hit_div_short) div_pl <= {1'b0, sr[DIV_W-2:0]};
         if (hit_feat) feat_pl <= sr[FEAT_HI:FEAT_LO];
      end
   end

   assert_band_at_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stb.band |-> cnt == CW'(BAND_W));
   assert_div_at_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb.div |-> (cnt == CW'(DIV_END)) || (cnt == '0));
   assert_short_msb_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.div && cnt == '0) |-> !div_pl[DIV_W-1]);
   assert_feat_at_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stb.feat |-> cnt == CW'(FRAME_MAX));
   assert_cnt_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(FRAME_MAX + 1));
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !en_d) |=> stb == '0);
   assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb));
endmodule

// File: rtl/tcr_bank.sv
module tcr_bank #(
   parameter int unsigned W   = 4,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (ld) q <= d;
   end

   assert_load_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> q == $past(d));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q));
endmodule

// File: rtl/tuner_ctl_rx.sv
module tuner_ctl_rx
   import tcr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BAND_W      = 4,
   parameter int unsigned DIV_W       = 15,
   parameter int unsigned FEAT_W      = 7,
   parameter int unsigned FRAME_MAX   = 34,
   parameter int unsigned DIV_POR     = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_en,
   input  logic              ser_clk,
   input  logic              ser_dat,
   output logic [BAND_W-1:0] band_q,
   output logic [DIV_W-1:0]  div_q,
   output logic [FEAT_W-1:0] feat_q,
   output logic              band_stb,
   output logic              div_stb,
   output logic              feat_stb
);
   localparam int unsigned NLINES = 3;

   generate
      if (DIV_POR >= (1 << DIV_W)) begin : g_bad_por
         $error("divider power-on value does not fit");
      end
   endgenerate

   logic [NLINES-1:0] raw, syn;
   assign raw = {ser_en, ser_clk, ser_dat};

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_sync
         tcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw[i]), .q(syn[i]));
      end
   endgenerate

   tcr_stb_t          stb;
   logic [BAND_W-1:0] band_pl;
   logic [DIV_W-1:0]  div_pl;
   logic [FEAT_W-1:0] feat_pl;

   tcr_frame #(
      .BAND_W(BAND_W), .DIV_W(DIV_W), .FEAT_W(FEAT_W), .FRAME_MAX(FRAME_MAX)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .en(syn[2]), .sck(syn[1]), .sdi(syn[0]),
      .stb(stb), .band_pl(band_pl), .div_pl(div_pl), .feat_pl(feat_pl));

   tcr_bank #(.W(BAND_W), .RST('0)) u_band (
      .clk(clk), .rst_n(rst_n), .ld(stb.band), .d(band_pl), .q(band_q));
   tcr_bank #(.W(DIV_W), .RST(DIV_W'(DIV_POR))) u_div (
      .clk(clk), .rst_n(rst_n), .ld(stb.div), .d(div_pl), .q(div_q));
   tcr_bank #(.W(FEAT_W), .RST('0)) u_feat (
      .clk(clk), .rst_n(rst_n), .ld(stb.feat), .d(feat_pl), .q(feat_q));

   assign band_stb = stb.band;
   assign div_stb  = stb.div;
   assign feat_stb = stb.feat;
endmodule

// File: tb/tuner_ctl_rx_bench.sv
module tuner_ctl_rx_bench;
   localparam int HP = 20;
   localparam int NF = 12;
   localparam logic [45:0] TAB [NF] = '{
      {6'd19, 40'hB7E5C9A3F1}, {6'd34, 40'h5C3A69D4E2}, {6'd18, 40'hFFFFFFFFFF},
      {6'd34, 40'h3FFFFFFFFF}, {6'd9,  40'h6000000000}, {6'd3,  40'h0000000000},
      {6'd40, 40'h9123456789}, {6'd30, 40'hE87654321F}, {6'd4,  40'h1FFFFFFFFF},
      {6'd18, 40'h2AAAAAAAAA}, {6'd34, 40'h0000000000}, {6'd19, 40'hD000123450}};

   logic clk = 0, rst_n = 0, ser_en = 0, ser_clk = 0, ser_dat = 0;
   logic [3:0] band_q; logic [14:0] div_q; logic [6:0] feat_q;
   logic band_stb, div_stb, feat_stb;
   int checks = 0, errors = 0, nb = 0, nd = 0, nt = 0, cyc = 0;
   logic [3:0] eb; logic [14:0] ed; logic [6:0] et;

   always #10 clk = ~clk;

   tuner_ctl_rx u_tuner_ctl_rx (.clk(clk), .rst_n(rst_n), .ser_en(ser_en),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .band_q(band_q), .div_q(div_q),
      .feat_q(feat_q), .band_stb(band_stb), .div_stb(div_stb), .feat_stb(feat_stb));

   always @(negedge clk) begin
      if (band_stb) nb++;
      if (div_stb)  nd++;
      if (feat_stb) nt++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input int len, input logic [39:0] fr);
      @(posedge clk); #1 ser_en = 1;
      repeat (HP) @(posedge clk);
      for (int p = 1; p <= len; p++) begin
         #1 ser_dat = fr[40-p];
         repeat (HP) @(posedge clk);
         #1 ser_clk = 1;
         repeat (HP) @(posedge clk);
         #1 ser_clk = 0;
      end
      repeat (HP) @(posedge clk);
      #1 ser_en = 0;
      repeat (HP) @(negedge clk);
   endtask

   initial begin
      eb = 4'h0; ed = 15'd256; et = 7'h0;
      repeat (5) @(negedge clk);
      // R1: values during and after reset
      chk("R1 div in reset", int'(div_q), 256);
      @(posedge clk); #1 rst_n = 1;
      repeat (5) @(negedge clk);
      chk("R1 band", int'(band_q), 0);
      chk("R1 div", int'(div_q), 256);
      chk("R1 feat ratio 512", int'(feat_q), 0);
      chk("R1 strobes", int'({band_stb, div_stb, feat_stb}), 0);

      for (int i = 0; i < NF; i++) begin
         int len; logic [39:0] fr;
         len = int'(TAB[i][45:40]); fr = TAB[i][39:0];
         nb = 0; nd = 0; nt = 0;
         send(len, fr);
         if (len >= 4)  eb = fr[39:36];              // R2 R6
         if (len >= 19) ed = fr[35:21];              // R3
         else if (len == 18) ed = {1'b0, fr[35:22]}; // R4
         if (len >= 34) et = fr[20:14];              // R5 R7
         chk("R2 R6 band", int'(band_q), int'(eb));
         chk((len == 18) ? "R4 div" : "R3 div", int'(div_q), int'(ed));
         chk((len > 34) ? "R7 feat" : "R5 feat", int'(feat_q), int'(et));
         chk("R9 strobe counts", nb * 100 + nd * 10 + nt,
             (len >= 4 ? 100 : 0) + (len >= 18 ? 10 : 0) + (len >= 34 ? 1 : 0));
      end

      // R8: shift clock activity with frame select low
      nb = 0; nd = 0; nt = 0;
      for (int k = 0; k < 25; k++) begin
         @(posedge clk); #1 ser_dat = k[0]; ser_clk = 1;
         repeat (HP) @(posedge clk); #1 ser_clk = 0;
         repeat (HP) @(posedge clk);
      end
      repeat (HP) @(negedge clk);
      chk("R8 band", int'(band_q), int'(eb));
      chk("R8 div", int'(div_q), int'(ed));
      chk("R8 feat", int'(feat_q), int'(et));
      chk("R8 strobes", nb + nd + nt, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule